// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of one eight-line priority interrupt controller. A single address bit picks between a command port (address 0) and a data port (address 1). Command writes either start a multi-word setup sequence or issue run-time operation words: end-of-interrupt variants, priority rotation, a one-shot poll, readback selection and special mask. Data writes feed the setup sequence while it runs and load the mask register otherwise. Reads return the mask, the request register or the in-service register, or a poll result.

The block does not own the request and in-service registers, and it does not search for priorities. A neighbouring resolver owns those registers and drives them in as `irr_in` and `isr_in`. The resolver also supplies the highest-priority in-service line and the poll candidate. In return, this block gives the resolver the mode bits, the vector base, the mask and the priority base. It also gives one-cycle clear strobes and an update strobe, so the resolver knows when to act.

Accesses are taken one per cycle, as `acc_valid` pulses. The port is always ready and has no back-pressure. Every read answers on the cycle after the access, with `rd_valid` high for one cycle. Every register and strobe output changes on the clock edge that accepts the access.

Top module: `pic_cmd_seq`

## Requirements
- R1: A command-port write with bit 4 set starts setup. It moves to the base step (`init_active`=1) and records bit 0 as "mode word expected". It zeroes the mask, vector base, priority base, all mode bits, readback select and poll. For one cycle it pulses `isr_clr`=FF, `irr_clr`=FF and `upd`.
- R2: In the base step, a data write sets `vec_base` to the byte with its low three bits forced to zero, and moves to the cascade step.
- R3: In the cascade step, the data byte is discarded. The block moves to the mode step if a mode word is expected, and otherwise back to normal (`init_active`=0).
- R4: In the mode step, data bit 4 sets `sfnm_en` and data bit 1 sets `aeoi_en`, and the block returns to normal. These bits change at no other time, except when setup starts.
- R5: In normal operation, a data write loads `mask_out` and pulses `upd`.
- R6: A command write with bit 4 = 0 and bit 3 = 1 is an operation word. Bit 2 arms the poll. Bit 1 = 1 loads the readback select from bit 0, where 1 selects in-service and 0 selects request. Bit 6 = 1 loads `smask_en` from bit 5.
- R7: A command write with bits 4 and 3 both 0 carries a code in bits 7:5. Code 0 clears `rot_aeoi_en` and code 4 sets it. Code 2 has no effect on any output.
- R8: Codes 1 and 5 pulse `isr_clr` at `hp_line` and pulse `upd`, but only when `hp_valid`=1. Code 5 also sets `pri_base` to (`hp_line`+1) mod 8. When `hp_valid`=0 they do nothing.
- R9: Code 3 pulses `isr_clr` at the line in bits 2:0. Code 6 sets `pri_base` to (bits 2:0 + 1) mod 8. Code 7 does both. Each of them pulses `upd`.
- R10: A data-port read returns `mask_out`. A command-port read without an armed poll returns `isr_in` or `irr_in`, according to the readback select. In both cases the data arrives on `rd_data` with `rd_valid` one cycle after the access.
- R11: A command-port read with the poll armed returns the poll result and disarms the poll. If `poll_valid`=1, the result is `poll_line`, and the block pulses `isr_clr`, `irr_clr` at that line and `upd`. If `poll_valid`=0, the result is 07h. A data-port read leaves the poll armed.
- R12: A setup-start write with bit 1 (single mode) or bit 3 (level mode) set raises `cfg_err`. This flag is sticky until reset.
- R13: A change of the priority base, a mask load or any in-service clear is accompanied by `upd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = command port, 1 = data port |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer |
| irr_in | input | 8 | Request register from resolver |
| isr_in | input | 8 | In-service register from resolver |
| hp_valid | input | 1 | An in-service bit is set |
| hp_line | input | 3 | Highest-priority in-service line |
| poll_valid | input | 1 | A request would be granted |
| poll_line | input | 3 | Line that would be granted |
| mask_out | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| pri_base | output | 3 | Line holding top priority |
| aeoi_en | output | 1 | Automatic end of interrupt |
| rot_aeoi_en | output | 1 | Rotate on automatic end of interrupt |
| sfnm_en | output | 1 | Special fully nested mode |
| smask_en | output | 1 | Special mask mode |
| init_active | output | 1 | Setup sequence in progress |
| isr_clr | output | 8 | One-cycle in-service clear strobe |
| irr_clr | output | 8 | One-cycle request clear strobe |
| upd | output | 1 | Resolver must re-evaluate |
| cfg_err | output | 1 | Unsupported setup option seen |

## Verification
Operation words are decoded in every step, so one can arrive while the setup sequence is only partly done. The block must then do two things at once: apply the command and hold its place in the setup sequence. The bench provokes this case by starting setup and then issuing a set-priority command before the data words. It checks that `pri_base` moves at once and that `init_active` stays high. It also checks that the data words that follow still land as vector base, discarded cascade word and mode word, and that the first data write after setup becomes the mask.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
  typedef enum logic [1:0] {
    STP_NORM = 2'd0,
    STP_BASE = 2'd1,
    STP_CASC = 2'd2,
    STP_MODE = 2'd3
  } init_step_e;

  // code field of a command write with bits 4 and 3 clear
  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_NSEOI   = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_RNSEOI  = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_code_e;

  typedef struct packed {
    logic start_init;
    logic ocw3;
    logic ocw2;
    logic data_wr;
    logic cmd_rd;
    logic data_rd;
  } acc_kind_t;
endpackage

// File: rtl/pic_acc_classify.sv
module pic_acc_classify
  import pic_seq_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_we,
  input  logic       acc_addr,
  input  logic [1:0] fmt_bits,   // write data bits 4:3
  output acc_kind_t  kind
);
  logic cmd_wr;
  assign cmd_wr = acc_valid & acc_we & ~acc_addr;

  always_comb begin
    kind.start_init = cmd_wr & fmt_bits[1];
    kind.ocw3       = cmd_wr & ~fmt_bits[1] & fmt_bits[0];
    kind.ocw2       = cmd_wr & ~fmt_bits[1] & ~fmt_bits[0];
    kind.data_wr    = acc_valid & acc_we & acc_addr;
    kind.cmd_rd     = acc_valid & ~acc_we & ~acc_addr;
    kind.data_rd    = acc_valid & ~acc_we & acc_addr;
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_t     kind,
  input  logic [DW-1:0] wdata,
  output init_step_e    step,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic          aeoi,
  output logic          sfnm,
  output logic          err,
  output logic          mask_pulse
);
  localparam logic [DW-1:0] BASE_KEEP = ~DW'(7);

  logic mode_expected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step          <= STP_NORM;
      mode_expected <= 1'b0;
      mask          <= '0;
      vec_base      <= '0;
      aeoi          <= 1'b0;
      sfnm          <= 1'b0;
      err           <= 1'b0;
      mask_pulse    <= 1'b0;
    end else begin
      mask_pulse <= 1'b0;
      if (kind.start_init) begin
        step          <= STP_BASE;
        mode_expected <= wdata[0];
        mask          <= '0;
        vec_base      <= '0;
        aeoi          <= 1'b0;
        sfnm          <= 1'b0;
        if (wdata[1] | wdata[3]) err <= 1'b1;
      end else if (kind.data_wr) begin
        case (step)
          STP_NORM: begin
            mask       <= wdata;
            mask_pulse <= 1'b1;
          end
          STP_BASE: begin
            vec_base <= wdata & BASE_KEEP;
            step     <= STP_CASC;
          end
          STP_CASC: step <= mode_expected ? STP_MODE : STP_NORM;
          default: begin
            sfnm <= wdata[4];
            aeoi <= wdata[1];
            step <= STP_NORM;
          end
        endcase
      end
    end
  end

  assert_icw1_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    kind.start_init |=> (step == STP_BASE && mask == '0));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kind.start_init && !(kind.data_wr && step == STP_MODE)) |=> $stable({aeoi, sfnm}));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_casc_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind.data_wr && !kind.start_init && step == STP_CASC) |=> (step != STP_CASC && step != STP_BASE));
endmodule

// File: rtl/pic_ocw_exec.sv
module pic_ocw_exec
  import pic_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_t     kind,
  input  logic [DW-1:0] wdata,
  input  logic          hp_valid,
  input  logic [$clog2(DW)-1:0] hp_line,
  input  logic          poll_valid,
  input  logic [$clog2(DW)-1:0] poll_line,
  output logic [$clog2(DW)-1:0] pri_base,
  output logic          rot_aeoi,
  output logic          smask,
  output logic          rsel,
  output logic          poll_arm,
  output logic [DW-1:0] isr_clr,
  output logic [DW-1:0] irr_clr,
  output logic          upd
);
  localparam int LW = $clog2(DW);

  function automatic logic [DW-1:0] line_bit(input logic [LW-1:0] n);
    line_bit    = '0;
    line_bit[n] = 1'b1;
  endfunction

  logic [LW-1:0] wline;
  assign wline = wdata[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_base <= '0;
      rot_aeoi <= 1'b0;
      smask    <= 1'b0;
      rsel     <= 1'b0;
      poll_arm <= 1'b0;
      isr_clr  <= '0;
      irr_clr  <= '0;
      upd      <= 1'b0;
    end else begin
      isr_clr <= '0;
      irr_clr <= '0;
      upd     <= 1'b0;
      if (kind.start_init) begin
        pri_base <= '0;
        rot_aeoi <= 1'b0;
        smask    <= 1'b0;
        rsel     <= 1'b0;
        poll_arm <= 1'b0;
        isr_clr  <= '1;
        irr_clr  <= '1;
        upd      <= 1'b1;
      end else if (kind.ocw3) begin
        if (wdata[2]) poll_arm <= 1'b1;
        if (wdata[1]) rsel     <= wdata[0];
        if (wdata[6]) smask    <= wdata[5];
      end else if (kind.ocw2) begin
        case (op_code_e'(wdata[7:5]))
          OP_ROT_CLR, OP_ROT_SET: rot_aeoi <= wdata[7];
          OP_NSEOI, OP_RNSEOI: begin
            if (hp_valid) begin
              isr_clr <= line_bit(hp_line);
              upd     <= 1'b1;
              if (wdata[7]) pri_base <= hp_line + LW'(1);
            end
          end
          OP_SEOI: begin
            isr_clr <= line_bit(wline);
            upd     <= 1'b1;
          end
          OP_SETPRI: begin
            pri_base <= wline + LW'(1);
            upd      <= 1'b1;
          end
          OP_RSEOI: begin
            isr_clr  <= line_bit(wline);
            pri_base <= wline + LW'(1);
            upd      <= 1'b1;
          end
          default: ;
        endcase
      end else if (kind.cmd_rd && poll_arm) begin
        poll_arm <= 1'b0;
        if (poll_valid) begin
          isr_clr <= line_bit(poll_line);
          irr_clr <= line_bit(poll_line);
          upd     <= 1'b1;
        end
      end
    end
  end

  assert_clr_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(isr_clr) || (&isr_clr)));

  assert_base_upd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pri_base) |-> upd);

  assert_isr_upd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr != '0) |-> upd);

  assert_poll_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind.cmd_rd && poll_arm) |=> !poll_arm);

  assert_no_hp_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind.ocw2 && wdata[6:5] == 2'b01 && !hp_valid) |=> (isr_clr == '0 && !upd));
endmodule

// File: rtl/pic_readback.sv
module pic_readback
  import pic_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_t     kind,
  input  logic          rsel,
  input  logic          poll_arm,
  input  logic          poll_valid,
  input  logic [$clog2(DW)-1:0] poll_line,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] NO_POLL = DW'(7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= kind.cmd_rd | kind.data_rd;
      if (kind.data_rd) begin
        rd_data <= mask;
      end else if (kind.cmd_rd) begin
        if (poll_arm) rd_data <= poll_valid ? DW'(poll_line) : NO_POLL;
        else          rd_data <= rsel ? isr_in : irr_in;
      end
    end
  end

  assert_data_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kind.data_rd |=> (rd_valid && rd_data == $past(mask)));

  assert_cmd_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kind.cmd_rd |=> rd_valid);
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic          acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic          hp_valid,
  input  logic [LW-1:0] hp_line,
  input  logic          poll_valid,
  input  logic [LW-1:0] poll_line,
  output logic [DW-1:0] mask_out,
  output logic [DW-1:0] vec_base,
  output logic [LW-1:0] pri_base,
  output logic          aeoi_en,
  output logic          rot_aeoi_en,
  output logic          sfnm_en,
  output logic          smask_en,
  output logic          init_active,
  output logic [DW-1:0] isr_clr,
  output logic [DW-1:0] irr_clr,
  output logic          upd,
  output logic          cfg_err
);
  acc_kind_t  kind;
  init_step_e step;
  logic       mask_pulse, ocw_upd, rsel, poll_arm;

  pic_acc_classify u_cls (
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .fmt_bits  (acc_wdata[4:3]),
    .kind      (kind)
  );

  pic_init_fsm #(.DW(DW)) u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .wdata      (acc_wdata),
    .step       (step),
    .mask       (mask_out),
    .vec_base   (vec_base),
    .aeoi       (aeoi_en),
    .sfnm       (sfnm_en),
    .err        (cfg_err),
    .mask_pulse (mask_pulse)
  );

  pic_ocw_exec #(.DW(DW)) u_ocw (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .wdata      (acc_wdata),
    .hp_valid   (hp_valid),
    .hp_line    (hp_line),
    .poll_valid (poll_valid),
    .poll_line  (poll_line),
    .pri_base   (pri_base),
    .rot_aeoi   (rot_aeoi_en),
    .smask      (smask_en),
    .rsel       (rsel),
    .poll_arm   (poll_arm),
    .isr_clr    (isr_clr),
    .irr_clr    (irr_clr),
    .upd        (ocw_upd)
  );

  pic_readback #(.DW(DW)) u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .rsel       (rsel),
    .poll_arm   (poll_arm),
    .poll_valid (poll_valid),
    .poll_line  (poll_line),
    .irr_in     (irr_in),
    .isr_in     (isr_in),
    .mask       (mask_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign init_active = (step != STP_NORM);
  assign upd         = mask_pulse | ocw_upd;

  assert_mask_upd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind.data_wr && step == STP_NORM && !kind.start_init) |=> upd);
endmodule

// File: tb/pic_cmd_seq_test.sv
module pic_cmd_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_we = 1'b0, acc_addr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] irr_in = 8'hA5, isr_in = 8'h3C;
  logic       hp_valid = 1'b0, poll_valid = 1'b0;
  logic [2:0] hp_line = '0, poll_line = '0;
  logic [7:0] mask_out, vec_base, isr_clr, irr_clr;
  logic [2:0] pri_base;
  logic       aeoi_en, rot_aeoi_en, sfnm_en, smask_en, init_active, upd, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irr_in(irr_in), .isr_in(isr_in), .hp_valid(hp_valid),
    .hp_line(hp_line), .poll_valid(poll_valid), .poll_line(poll_line),
    .mask_out(mask_out), .vec_base(vec_base), .pri_base(pri_base),
    .aeoi_en(aeoi_en), .rot_aeoi_en(rot_aeoi_en), .sfnm_en(sfnm_en),
    .smask_en(smask_en), .init_active(init_active), .isr_clr(isr_clr),
    .irr_clr(irr_clr), .upd(upd), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [7:0] bit_of(input int n);
    return 8'(1) << n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] e_base;
    logic       e_rot, e_smask, e_rsel, e_poll;
    logic [7:0] e_data;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("reset R5 mask", mask_out, 8'h00);
    check("reset R2 base", vec_base, 8'h00);
    check("reset R3 init_active", {7'd0, init_active}, 8'd0);
    check("reset R12 err", {7'd0, cfg_err}, 8'd0);
    check("reset R10 rd_valid", {7'd0, rd_valid}, 8'd0);

    // setup sequence sweep
    for (int four = 1; four >= 0; four--) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] b, m;
        b = 8'(i * 17 + 3);
        m = 8'(i * 5);
        wr(1'b0, 8'h10 | 8'(four));
        check("R1 isr_clr", isr_clr, 8'hFF);
        check("R1 irr_clr", irr_clr, 8'hFF);
        check("R1 upd/active", {6'd0, upd, init_active}, 8'h03);
        check("R1 cleared", {mask_out[0] | (|mask_out), aeoi_en, sfnm_en, 5'd0}, 8'h00);
        check("R12 no err", {7'd0, cfg_err}, 8'd0);
        wr(1'b1, b);
        check("R2 vec_base", vec_base, b & 8'hF8);
        wr(1'b1, 8'hFF);
        check("R3 branch", {7'd0, init_active}, 8'(four));
        if (four == 1) begin
          wr(1'b1, m);
          check("R4 mode bits", {6'd0, sfnm_en, aeoi_en}, {6'd0, m[4], m[1]});
          check("R4 back to normal", {7'd0, init_active}, 8'd0);
        end
        check("R2 base kept", vec_base, b & 8'hF8);
      end
    end

    // mask sweep with readback
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      check("R5 mask", mask_out, 8'(v));
      check("R5 upd", {7'd0, upd}, 8'd1);
      rd(1'b1);
      check("R10 data read", rd_data, 8'(v));
      check("R10 rd_valid", {7'd0, rd_valid}, 8'd1);
    end

    // code sweep
    e_base = 3'd0; e_rot = 1'b0;
    for (int code = 0; code < 8; code++) begin
      for (int ln = 0; ln < 8; ln++) begin
        for (int hv = 0; hv < 2; hv++) begin
          logic [7:0] e_clr;
          logic       e_upd;
          hp_valid = hv[0];
          hp_line  = 3'(7 - ln);
          e_clr = 8'h00; e_upd = 1'b0;
          case (code)
            0, 4: e_rot = (code == 4);
            1, 5: if (hv == 1) begin
              e_clr = bit_of(7 - ln); e_upd = 1'b1;
              if (code == 5) e_base = 3'((7 - ln + 1) % 8);
            end
            3: begin e_clr = bit_of(ln); e_upd = 1'b1; end
            6: begin e_base = 3'((ln + 1) % 8); e_upd = 1'b1; end
            7: begin e_clr = bit_of(ln); e_base = 3'((ln + 1) % 8); e_upd = 1'b1; end
            default: ;
          endcase
          wr(1'b0, {3'(code), 2'b00, 3'(ln)});
          if (code == 1 || code == 5) check("R8 isr_clr", isr_clr, e_clr);
          else if (code == 2) check("R7 nop isr_clr", isr_clr, e_clr);
          else check("R9 isr_clr", isr_clr, e_clr);
          check("R13 upd", {7'd0, upd}, {7'd0, e_upd});
          check("R9 pri_base", {5'd0, pri_base}, {5'd0, e_base});
          check("R7 rot", {7'd0, rot_aeoi_en}, {7'd0, e_rot});
          check("R7 irr_clr idle", irr_clr, 8'h00);
        end
      end
    end
    hp_valid = 1'b0;

    // operation word and poll sweep
    e_smask = 1'b0; e_rsel = 1'b0; e_poll = 1'b0;
    for (int p = 0; p < 32; p++) begin
      logic [7:0] d;
      d = {1'b0, p[4], p[3], 2'b01, p[2], p[1], p[0]};
      if (p[2]) e_poll = 1'b1;
      if (p[1]) e_rsel = p[0];
      if (p[4]) e_smask = p[3];
      wr(1'b0, d);
      check("R6 smask", {7'd0, smask_en}, {7'd0, e_smask});
      poll_valid = p[0] ^ p[3];
      poll_line  = 3'(p * 3);
      if (e_poll) begin
        rd(1'b1);
        check("R11 data read keeps poll", rd_data, mask_out);
      end
      rd(1'b0);
      if (e_poll) begin
        e_data = poll_valid ? 8'(poll_line) : 8'h07;
        check("R11 poll data", rd_data, e_data);
        check("R11 isr_clr", isr_clr, poll_valid ? bit_of(int'(poll_line)) : 8'h00);
        check("R11 irr_clr", irr_clr, poll_valid ? bit_of(int'(poll_line)) : 8'h00);
        e_poll = 1'b0;
      end else begin
        check("R6 readback", rd_data, e_rsel ? isr_in : irr_in);
      end
      check("R10 cmd rd_valid", {7'd0, rd_valid}, 8'd1);
    end

    // command during setup
    wr(1'b0, 8'h11);
    wr(1'b0, {3'd6, 5'd4});
    check("R9 base during setup", {5'd0, pri_base}, 8'd5);
    check("R3 still in setup", {7'd0, init_active}, 8'd1);
    wr(1'b1, 8'h9B);
    check("R2 base after cmd", vec_base, 8'h98);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h12);
    check("R4 mode after cmd", {6'd0, sfnm_en, aeoi_en}, 8'h03);
    wr(1'b1, 8'h33);
    check("R5 mask after setup", mask_out, 8'h33);

    // unsupported options
    wr(1'b0, 8'h1A);
    check("R12 err set", {7'd0, cfg_err}, 8'd1);
    wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    wr(1'b0, 8'h10);
    check("R12 err sticky", {7'd0, cfg_err}, 8'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule